// File: doc/BRIEF.md
# DMA Channel Interrupt Status and Enable Unit

This block keeps the interrupt status of a single DMA channel and turns it into two request lines: one for error conditions and one for normal completion. Pulses from the channel's transfer engine report a finished frame in chained-block mode, the end of a whole transfer, and each new transfer request. The engine also supplies the current and error descriptor addresses. When a new request arrives while these two addresses are equal, the descriptor ring has run dry and the buffer error is raised.

Software sees three small registers through a simple write-strobe, select and combinational-read interface. The first is a status register, where each written 1 clears its bit. The second holds one enable bit per source. The third is a control register that enables the frame-end counter, selects chained mode, and carries a self-clearing counter-clear command. The frame-end counter queues unacknowledged end-of-frame events. End-of-message stays visible while any event is queued, so software acknowledges frames one at a time. A sixteenth queued frame raises a counter-overflow error.

Top module: `dma_irq_unit`

## Requirements
- R1: After reset the status, enable and control registers all read 0: single-block mode, counter disabled, count 0. Both request outputs are low.
- R2: A transfer-done pulse sets status bit 0 (end-of-transfer), readable on the cycle after the pulse.
- R3: A transfer-request pulse sets status bit 2 (buffer error) only when the error descriptor address equals the current descriptor address. Unequal addresses leave it clear.
- R4: In chained mode (control bit 1) with the counter enabled (control bit 0), each frame-end pulse adds one to the count, read at control bits [7:4]. Status bit 1 (end-of-message) reads 1 while the count is nonzero.
- R5: A frame-end that would make sixteen queued events sets status bit 3 (counter overflow), and the count holds at 15.
- R6: Writing 1 to a status bit clears it and writing 0 leaves it alone. A 1 written to bit 1 also lowers a nonzero count by one. At zero it has no effect on the count.
- R7: Writing control bit 7 zeroes the count on that cycle. After a status-bit-1 clear and this command, end-of-message reads 0.
- R8: A counted frame-end and an end-of-message acknowledge in the same cycle leave the count unchanged.
- R9: A status-setting event in the same cycle as a write-one-to-clear of that bit leaves the bit set.
- R10: The enable register uses the status bit positions. The error request is high exactly when bit 3 or bit 2 is set together with its enable. The normal request is high exactly when bit 1 or bit 0 is set together with its enable. A raised request stays high until its status bit or its enable is cleared.
- R11: In single-block mode a frame-end pulse changes neither status nor count. In chained mode with the counter disabled, it sets end-of-message and the count stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_frame_end | input | 1 | One-cycle pulse: a frame finished in chained-block mode |
| ev_xfer_done | input | 1 | One-cycle pulse: the whole DMA transfer finished |
| ev_xfer_req | input | 1 | One-cycle pulse: a new transfer request was issued |
| cur_desc_addr | input | ADDR_W | Current descriptor address |
| err_desc_addr | input | ADDR_W | Error (end-of-ring) descriptor address |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 status, 1 enable, 2 control |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Combinational read data of the selected register |
| irq_err | output | 1 | Error interrupt request |
| irq_norm | output | 1 | Normal-end interrupt request |

## Verification
The bench builds the unit with an 8-bit descriptor address, an 8-bit register width and the default 4-bit counter. The 4-bit counter brings saturation within reach in only sixteen frame events, so the bench can walk the count through every value from empty to overflow and back down by single acknowledges. Because there are just four status sources, it can also cover every combination of cleared status mask and enable mask when checking both request outputs arithmetically.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

    // Interrupt sources; the packing order fixes the status bit positions.
    typedef struct packed {
        logic cof;      // bit 3: frame-end counter overflow
        logic buf_err;  // bit 2: buffer overrun/underrun
        logic eom;      // bit 1: end of message (frame)
        logic eot;      // bit 0: end of transfer
    } irq_vec_t;

    localparam int NUM_SRC = $bits(irq_vec_t);

    typedef enum logic [1:0] {
        SEL_STATUS  = 2'd0,
        SEL_ENABLE  = 2'd1,
        SEL_CONTROL = 2'd2,
        SEL_NONE    = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic chain;    // control bit 1
        logic cnt_en;   // control bit 0
    } ctrl_t;

    localparam int CTRL_W     = $bits(ctrl_t);
    localparam int CTRL_CLR   = 7;
    localparam int CNT_LSB    = 4;

    function automatic logic err_request(irq_vec_t st, irq_vec_t en);
        return (st.cof & en.cof) | (st.buf_err & en.buf_err);
    endfunction

    function automatic logic norm_request(irq_vec_t st, irq_vec_t en);
        return (st.eom & en.eom) | (st.eot & en.eot);
    endfunction

endpackage

// File: rtl/dma_irq_fec.sv
module dma_irq_fec #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             dec,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt_q,
    output logic             full_hit
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic dec_ok;
    logic at_max;

    always_comb begin
        dec_ok   = dec && (cnt_q != '0);
        at_max   = (cnt_q == CNT_MAX);
        // one more pending event than the counter can hold
        full_hit = inc && !dec_ok && !clr && at_max;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc && !dec_ok && !at_max) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (dec_ok && !inc) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/dma_irq_flags.sv
module dma_irq_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] w1c_i,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                q[i] <= 1'b0;
            end else if (set_i[i]) begin
                q[i] <= 1'b1;       // event beats a clear in the same cycle
            end else if (w1c_i[i]) begin
                q[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dma_irq_unit.sv
module dma_irq_unit
    import dma_irq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_frame_end,
    input  logic              ev_xfer_done,
    input  logic              ev_xfer_req,
    input  logic [ADDR_W-1:0] cur_desc_addr,
    input  logic [ADDR_W-1:0] err_desc_addr,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_err,
    output logic              irq_norm
);
    localparam int CNT_TOP = CNT_LSB + CNT_W;

    reg_sel_e         sel;
    logic             wr_stat, wr_en, wr_ctrl;
    logic             clr_cmd;
    irq_vec_t         w1c;
    irq_vec_t         set_ev;
    irq_vec_t         flags_q;
    irq_vec_t         status_vis;
    irq_vec_t         en_q;
    ctrl_t            ctrl_q;
    logic             fe_live;
    logic             cnt_inc;
    logic             cnt_dec;
    logic             full_hit;
    logic [CNT_W-1:0] cnt_q;

    // ---------------- register decode ----------------
    always_comb begin
        sel     = reg_sel_e'(reg_sel);
        wr_stat = reg_wr && (sel == SEL_STATUS);
        wr_en   = reg_wr && (sel == SEL_ENABLE);
        wr_ctrl = reg_wr && (sel == SEL_CONTROL);
        clr_cmd = wr_ctrl && reg_wdata[CTRL_CLR];
        w1c     = wr_stat ? irq_vec_t'(reg_wdata[NUM_SRC-1:0]) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            ctrl_q <= '0;
        end else begin
            if (wr_en)   en_q   <= irq_vec_t'(reg_wdata[NUM_SRC-1:0]);
            if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
        end
    end

    // ---------------- event qualification ----------------
    always_comb begin
        fe_live        = ev_frame_end && ctrl_q.chain;
        cnt_inc        = fe_live && ctrl_q.cnt_en;
        cnt_dec        = w1c.eom;
        set_ev.eot     = ev_xfer_done;
        set_ev.buf_err = ev_xfer_req && (cur_desc_addr == err_desc_addr);
        set_ev.eom     = fe_live;
        set_ev.cof     = full_hit;
    end

    dma_irq_fec #(.CNT_W(CNT_W)) u_fec (
        .clk      (clk),
        .rst      (rst),
        .inc      (cnt_inc),
        .dec      (cnt_dec),
        .clr      (clr_cmd),
        .cnt_q    (cnt_q),
        .full_hit (full_hit)
    );

    dma_irq_flags #(.N(NUM_SRC)) u_flags (
        .clk   (clk),
        .rst   (rst),
        .set_i (set_ev),
        .w1c_i (w1c),
        .q     (flags_q)
    );

    // ---------------- visible status, requests, read ----------------
    always_comb begin
        status_vis     = flags_q;
        status_vis.eom = flags_q.eom | (ctrl_q.cnt_en && (cnt_q != '0));
        irq_err        = err_request(status_vis, en_q);
        irq_norm       = norm_request(status_vis, en_q);
    end

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_STATUS:  reg_rdata[NUM_SRC-1:0] = status_vis;
            SEL_ENABLE:  reg_rdata[NUM_SRC-1:0] = en_q;
            SEL_CONTROL: begin
                reg_rdata[CTRL_W-1:0]        = ctrl_q;
                reg_rdata[CNT_TOP-1:CNT_LSB] = cnt_q;
            end
            default:     reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dma_irq_unit_chk.sv
module dma_irq_unit_chk #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              ev_xfer_done,
    input logic              ev_xfer_req,
    input logic              ev_frame_end,
    input logic [ADDR_W-1:0] cur_desc_addr,
    input logic [ADDR_W-1:0] err_desc_addr,
    input logic              chain,
    input logic              cnt_inc,
    input logic              cnt_dec,
    input logic              clr_cmd,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [3:0]        flags_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // R2: transfer done is always recorded
    p_eot_set_r2: assert property (@(posedge clk) disable iff (rst)
        ev_xfer_done |=> flags_q[0]);

    // R3: request at matching descriptor addresses records a buffer error
    p_buf_set_r3: assert property (@(posedge clk) disable iff (rst)
        (ev_xfer_req && cur_desc_addr == err_desc_addr) |=> flags_q[2]);

    // R4: counted frame-end raises the count by one
    p_count_up_r4: assert property (@(posedge clk) disable iff (rst)
        (cnt_inc && !cnt_dec && !clr_cmd && cnt_q != CNT_MAX)
        |=> (cnt_q - $past(cnt_q)) == CNT_W'(1));

    // R5: the sixteenth pending event sets overflow and the count stays full
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        (cnt_inc && !cnt_dec && !clr_cmd && cnt_q == CNT_MAX)
        |=> (flags_q[3] && cnt_q == CNT_MAX));

    // R6: acknowledge at zero leaves the count at zero
    p_dec_at_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (cnt_dec && !cnt_inc && !clr_cmd && cnt_q == '0) |=> cnt_q == '0);

    // R7: clear command empties the counter
    p_clear_cmd_r7: assert property (@(posedge clk) disable iff (rst)
        clr_cmd |=> cnt_q == '0);

    // R8: simultaneous increment and decrement hold the count
    p_inc_dec_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (cnt_inc && cnt_dec && !clr_cmd) |=> $stable(cnt_q));

    // R11: frame-end in single-block mode leaves the count alone
    p_single_ignored_r11: assert property (@(posedge clk) disable iff (rst)
        (ev_frame_end && !chain && !cnt_dec && !clr_cmd) |=> $stable(cnt_q));
endmodule

bind dma_irq_unit dma_irq_unit_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .ev_xfer_done  (ev_xfer_done),
    .ev_xfer_req   (ev_xfer_req),
    .ev_frame_end  (ev_frame_end),
    .cur_desc_addr (cur_desc_addr),
    .err_desc_addr (err_desc_addr),
    .chain         (ctrl_q.chain),
    .cnt_inc       (cnt_inc),
    .cnt_dec       (cnt_dec),
    .clr_cmd       (clr_cmd),
    .cnt_q         (cnt_q),
    .flags_q       (flags_q)
);

// File: tb/dma_irq_unit_test.sv
`timescale 1ns/1ps
module dma_irq_unit_test;
    localparam int ADDR_W = 8;
    localparam int CNT_W  = 4;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ev_frame_end = 1'b0;
    logic              ev_xfer_done = 1'b0;
    logic              ev_xfer_req  = 1'b0;
    logic [ADDR_W-1:0] cur_desc_addr = 8'h10;
    logic [ADDR_W-1:0] err_desc_addr = 8'h20;
    logic              reg_wr = 1'b0;
    logic [1:0]        reg_sel = 2'd0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              irq_err, irq_norm;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;   // 50 MHz

    dma_irq_unit #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst(rst),
        .ev_frame_end(ev_frame_end), .ev_xfer_done(ev_xfer_done), .ev_xfer_req(ev_xfer_req),
        .cur_desc_addr(cur_desc_addr), .err_desc_addr(err_desc_addr),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_err(irq_err), .irq_norm(irq_norm)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one clock of stimulus, driven at a falling edge, removed at the next
    task automatic step(input logic fe, input logic xd, input logic xr,
                        input logic wr, input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        ev_frame_end = fe; ev_xfer_done = xd; ev_xfer_req = xr;
        reg_wr = wr; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        ev_frame_end = 0; ev_xfer_done = 0; ev_xfer_req = 0; reg_wr = 0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [7:0] v);
        reg_sel = sel;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        step(0, 0, 0, 1, sel, d);
    endtask

    task automatic set_all();
        wr(2, 8'h83);
        repeat (16) step(1, 0, 0, 0, 0, 0);
        step(0, 1, 0, 0, 0, 0);
        err_desc_addr = cur_desc_addr;
        step(0, 0, 1, 0, 0, 0);
        err_desc_addr = 8'h20;
        wr(2, 8'h83);           // count back to 0, latched flags remain
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        rd(0, v); chk("R1 status", v, 0);
        rd(1, v); chk("R1 enable", v, 0);
        rd(2, v); chk("R1 control", v, 0);
        chk("R1 irq_err", irq_err, 0);
        chk("R1 irq_norm", irq_norm, 0);

        // R11 single-block mode ignores frame end
        step(1, 0, 0, 0, 0, 0);
        rd(0, v); chk("R11 single status", v, 0);
        rd(2, v); chk("R11 single count", v, 0);

        // R2 end of transfer, R10 request gating, R6 write-one-to-clear
        step(0, 1, 0, 0, 0, 0);
        rd(0, v); chk("R2 eot set", v, 8'h01);
        chk("R10 gated off", irq_norm, 0);
        wr(1, 8'h01);
        chk("R10 enabled", irq_norm, 1);
        repeat (3) @(negedge clk);
        chk("R10 held", irq_norm, 1);
        wr(0, 8'h0E);
        rd(0, v); chk("R6 zero no effect", v, 8'h01);
        wr(0, 8'h01);
        rd(0, v); chk("R6 cleared", v, 0);
        chk("R10 dropped", irq_norm, 0);
        wr(1, 8'h00);

        // R3 buffer error
        step(0, 0, 1, 0, 0, 0);
        rd(0, v); chk("R3 unequal", v, 0);
        err_desc_addr = cur_desc_addr;
        step(0, 0, 1, 0, 0, 0);
        err_desc_addr = 8'h20;
        rd(0, v); chk("R3 equal", v, 8'h04);
        wr(0, 8'h04);

        // R4 / R5 sweep of pending frame count
        wr(2, 8'h83);
        for (int n = 1; n <= 18; n++) begin
            step(1, 0, 0, 0, 0, 0);
            rd(2, v); chk("R5 count", v[7:4], (n > 15) ? 15 : n);
            rd(0, v);
            chk("R4 eom", v[1], 1);
            chk("R5 overflow", v[3], (n >= 16) ? 1 : 0);
        end
        wr(0, 8'h08);

        // R6 acknowledge walks the count down
        for (int k = 14; k >= 0; k--) begin
            wr(0, 8'h02);
            rd(2, v); chk("R6 count dec", v[7:4], k);
            rd(0, v); chk("R6 eom", v[1], (k != 0) ? 1 : 0);
        end
        wr(0, 8'h02);
        rd(2, v); chk("R6 dec at zero", v[7:4], 0);

        // R8 increment with acknowledge in one cycle
        repeat (3) step(1, 0, 0, 0, 0, 0);
        step(1, 0, 0, 1, 0, 8'h02);
        rd(2, v); chk("R8 hold", v[7:4], 3);

        // R7 two-step clear
        wr(0, 8'h02);
        rd(0, v); chk("R7 eom after w1c", v[1], 1);
        wr(2, 8'h83);
        rd(2, v); chk("R7 count zero", v[7:4], 0);
        rd(0, v); chk("R7 eom clear", v[1], 0);

        // R9 event wins over clear
        step(0, 1, 0, 1, 0, 8'h01);
        rd(0, v); chk("R9 set wins", v[0], 1);
        wr(0, 8'h01);

        // R11 chained with counter disabled
        wr(2, 8'h02);
        step(1, 0, 0, 0, 0, 0);
        rd(0, v); chk("R11 eom flag", v, 8'h02);
        rd(2, v); chk("R11 no count", v[7:4], 0);
        wr(0, 8'h02);

        // R10 sweep: every cleared-mask by every enable mask
        for (int m = 0; m < 16; m++) begin
            set_all();
            wr(0, 8'(m));
            rd(0, v); chk("R6 mask clear", v, (~m) & 15);
            for (int e = 0; e < 16; e++) begin
                wr(1, 8'(e));
                chk("R10 irq_err", irq_err, (((~m) & e & 12) != 0) ? 1 : 0);
                chk("R10 irq_norm", irq_norm, (((~m) & e & 3) != 0) ? 1 : 0);
            end
            wr(0, 8'h0F);
            wr(1, 8'h00);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule